// File: doc/BRIEF.md
# Interrupt Status and Coprocessor Control Word

This block is one 16-bit register that a host reads and writes as a single word. It gathers three interrupt events: audio DMA done, auxiliary-memory DMA done, and a coprocessor request. It also holds the control levels for the coprocessor (reset, interrupt assert, halt, init) and a flag that shows an auxiliary-memory DMA is in flight. Each event has a status bit with its own enable bit placed right above it. The block drives one combined interrupt line to the host interrupt controller.

Event sources raise status bits with one-cycle set pulses. Software clears a status bit by writing 1 to it, and a 0 in that position leaves the bit alone. The control levels, the enables and the padding nibble take the written value directly. The busy flag is set by a DMA start pulse and cleared when the DMA-done event is raised. Software cannot write the busy flag. On a read, the five coprocessor-owned positions come from the coprocessor's own status input, and every other position comes from the stored word.

Top module: `irq_ctl_reg`

## Requirements
- R1: `rd_data` bits 0, 1, 2, 10 and 11 (mask 0x0C07) equal the same bits of `cop_ctl_in`. All other bits of `rd_data` equal the same bits of `reg_q`.
- R2: The status bits sit at bit 3 (audio), bit 5 (aux DMA) and bit 7 (coprocessor). A write with 1 in a status position clears that bit. A write with 0 there leaves it unchanged.
- R3: A write stores the written value directly in these bits: the enable bits 4, 6 and 8; the control bits 0 (reset), 1 (assert), 2 (halt) and 11 (init); and bit 10. The stored word is visible on `reg_q` the cycle after the write.
- R4: `irq_out` is high exactly when some status bit and the enable bit directly above it are both 1.
- R5: Bit 9 is the busy flag. A pulse on `auxdma_start` sets it. A pulse on `auxdma_set` clears it. When both pulse in the same cycle, the flag ends up 0.
- R6: After a synchronous reset, `reg_q` is 0x0004: only the halt bit is set.
- R7: Bits 15:12 store the written value. `pad_err` is high while the stored value of those bits is nonzero.
- R8: When a source set pulse and a software write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R9: A write does not change the busy flag (bit 9), whatever the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the word |
| wr_data | input | 16 | Write value |
| cop_ctl_in | input | 16 | Coprocessor-side status, used for read bits 0x0C07 |
| audio_set | input | 1 | Audio DMA done pulse |
| auxdma_set | input | 1 | Auxiliary DMA done pulse |
| cop_set | input | 1 | Coprocessor interrupt pulse |
| auxdma_start | input | 1 | Auxiliary DMA start pulse (sets busy) |
| rd_data | output | 16 | Read value |
| reg_q | output | 16 | Stored word, toward the coprocessor |
| irq_out | output | 1 | Combined interrupt line |
| pad_err | output | 1 | Padding nibble is nonzero |

## Verification
Each source is raised in turn, first with its enable bit off and then with it on. This separates a status bit that latches from an interrupt line that follows the enable. Writes that carry 1 only in a status position are compared with writes that carry 0 there, to show that clearing is selective. Pulses that collide with clears, and busy start/done pulses in the same cycle, settle the two priority rules. Reads with the coprocessor input at all-ones and at all-zeros show which bits come from which side.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int WORD_W  = 16;
    localparam int NSRC    = 3;

    localparam int POS_RST  = 0;
    localparam int POS_ASRT = 1;
    localparam int POS_HALT = 2;
    localparam int POS_BUSY = 9;
    localparam int POS_RSV  = 10;
    localparam int POS_INIT = 11;
    localparam int PAD_LO   = 12;
    localparam int PAD_W    = WORD_W - PAD_LO;

    localparam logic [WORD_W-1:0] COP_OWNED  = 16'h0C07;
    localparam logic [WORD_W-1:0] RESET_WORD = 16'h0004;

    // source index: 0 audio, 1 aux DMA, 2 coprocessor
    function automatic int src_pos(input int idx);
        return 3 + 2 * idx;
    endfunction

    function automatic logic [WORD_W-1:0] direct_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        m[POS_RST]  = 1'b1;
        m[POS_ASRT] = 1'b1;
        m[POS_HALT] = 1'b1;
        m[POS_RSV]  = 1'b1;
        m[POS_INIT] = 1'b1;
        for (int i = 0; i < NSRC; i++) m[src_pos(i) + 1] = 1'b1;
        for (int i = PAD_LO; i < WORD_W; i++) m[i] = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        logic set;
        logic clr;
    } evt_t;

endpackage

// File: rtl/irq_status_bit.sv
module irq_status_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    assert_w1c_R2: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !set_i) |=> $stable(q));
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q);
endmodule

// File: rtl/irq_busy_flag.sv
module irq_busy_flag (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic done_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= 1'b0;
        else if (done_i)  q <= 1'b0;
        else if (start_i) q <= 1'b1;
    end

    assert_busy_clr_R5: assert property (@(posedge clk) disable iff (rst)
        done_i |=> !q);
    assert_busy_set_R5: assert property (@(posedge clk) disable iff (rst)
        (start_i && !done_i) |=> q);
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
    import irq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] cop_ctl_in,
    input  logic              audio_set,
    input  logic              auxdma_set,
    input  logic              cop_set,
    input  logic              auxdma_start,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] reg_q,
    output logic              irq_out,
    output logic              pad_err
);
    localparam logic [WORD_W-1:0] DMASK = direct_mask();

    logic [NSRC-1:0]   src_pulse;
    logic [NSRC-1:0]   stat_q;
    logic [NSRC-1:0]   en_bits;
    evt_t [NSRC-1:0]   evt;
    logic [WORD_W-1:0] direct_q;
    logic              busy_q;
    logic              rst_seen_q;

    assign src_pulse = {cop_set, auxdma_set, audio_set};

    always_ff @(posedge clk) begin
        if (rst)        direct_q <= RESET_WORD & DMASK;
        else if (wr_en) direct_q <= wr_data & DMASK;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign evt[g].set = src_pulse[g];
        assign evt[g].clr = wr_en & wr_data[src_pos(g)];
        assign en_bits[g] = direct_q[src_pos(g) + 1];
        irq_status_bit u_bit (
            .clk   (clk),
            .rst   (rst),
            .set_i (evt[g].set),
            .clr_i (evt[g].clr),
            .q     (stat_q[g])
        );
    end

    irq_busy_flag u_busy (
        .clk     (clk),
        .rst     (rst),
        .start_i (auxdma_start),
        .done_i  (auxdma_set),
        .q       (busy_q)
    );

    always_comb begin
        reg_q = direct_q;
        reg_q[POS_BUSY] = busy_q;
        for (int i = 0; i < NSRC; i++) reg_q[src_pos(i)] = stat_q[i];
    end

    assign rd_data = (reg_q & ~COP_OWNED) | (cop_ctl_in & COP_OWNED);
    assign irq_out = |(stat_q & en_bits);
    assign pad_err = |direct_q[WORD_W-1:PAD_LO];

    always_ff @(posedge clk) rst_seen_q <= rst;

    always_ff @(posedge clk) begin
        if (!rst && rst_seen_q) begin
            assert_reset_R6: assert (reg_q == RESET_WORD)
                else $error("reset word %h", reg_q);
        end
    end

    assert_pad_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_data[WORD_W-1:PAD_LO] != '0)) |=> pad_err);
    assert_busy_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !auxdma_start && !auxdma_set) |=> $stable(reg_q[POS_BUSY]));
    assert_irq_masked_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[4] == 1'b0 && wr_data[6] == 1'b0 && wr_data[8] == 1'b0)
        |=> !irq_out);
endmodule

// File: tb/irq_ctl_reg_bench.sv
module irq_ctl_reg_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] cop_ctl_in;
    logic        audio_set, auxdma_set, cop_set, auxdma_start;
    logic [15:0] rd_data, reg_q;
    logic        irq_out, pad_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m;
    bit finished = 0;

    localparam logic [15:0] DM = 16'hFD57;

    always #2.5 clk = ~clk;

    irq_ctl_reg u_irq_ctl_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .cop_ctl_in(cop_ctl_in), .audio_set(audio_set), .auxdma_set(auxdma_set),
        .cop_set(cop_set), .auxdma_start(auxdma_start), .rd_data(rd_data),
        .reg_q(reg_q), .irq_out(irq_out), .pad_err(pad_err)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic model_irq(input logic [15:0] w);
        return (w[3] & w[4]) | (w[5] & w[6]) | (w[7] & w[8]);
    endfunction

    // one clock cycle with given stimulus; model updated per the requirements
    task automatic step(input bit we, input logic [15:0] wd,
                        input bit a, input bit x, input bit c, input bit st);
        logic [15:0] n;
        wr_en = we; wr_data = wd; audio_set = a; auxdma_set = x;
        cop_set = c; auxdma_start = st;
        n = m;
        if (we) begin
            n = (n & ~DM) | (wd & DM);
            n = n & ~(wd & 16'h00A8);
        end
        if (a) n[3] = 1'b1;
        if (x) n[5] = 1'b1;
        if (c) n[7] = 1'b1;
        if (x) n[9] = 1'b0;
        else if (st) n[9] = 1'b1;
        @(posedge clk); #1;
        m = n;
        wr_en = 0; audio_set = 0; auxdma_set = 0; cop_set = 0; auxdma_start = 0;
    endtask

    task automatic t_reset();
        rst = 1; step(0, 0, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0);
        rst = 0; m = 16'h0004;
        chk("R6 reset word", reg_q, 16'h0004);
        chk("R6 irq idle", {15'd0, irq_out}, 16'd0);
        chk("R7 pad_err idle", {15'd0, pad_err}, 16'd0);
    endtask

    task automatic t_sources();
        for (int s = 0; s < 3; s++) begin
            step(1, 16'h00A8, 0, 0, 0, 0);
            step(0, 0, s == 0, s == 1, s == 2, 0);
            chk("R2 status latched", reg_q, m);
            chk("R4 irq masked off", {15'd0, irq_out}, {15'd0, model_irq(m)});
            step(1, 16'h0001 << (4 + 2 * s), 0, 0, 0, 0);
            chk("R3 enable stored", reg_q, m);
            chk("R4 irq enabled", {15'd0, irq_out}, 16'd1);
        end
    endtask

    task automatic t_w1c();
        step(0, 0, 1, 1, 1, 0);
        step(1, 16'h0020, 0, 0, 0, 0);
        chk("R2 selective clear", reg_q, m);
        chk("R2 others kept", {13'd0, reg_q[7], reg_q[5], reg_q[3]}, 16'h0005);
        step(1, 16'h0000, 0, 0, 0, 0);
        chk("R2 write zero keeps", reg_q, m);
        chk("R4 no enable no irq", {15'd0, irq_out}, 16'd0);
    endtask

    task automatic t_prio();
        step(1, 16'h0100, 0, 0, 1, 0);
        step(1, 16'h0180, 0, 0, 1, 0);
        chk("R8 set beats clear", reg_q, m);
        chk("R8 irq after collision", {15'd0, irq_out}, 16'd1);
    endtask

    task automatic t_busy();
        step(0, 0, 0, 0, 0, 1);
        chk("R5 busy set", {15'd0, reg_q[9]}, 16'd1);
        step(1, 16'h0000, 0, 0, 0, 0);
        chk("R9 write keeps busy", {15'd0, reg_q[9]}, 16'd1);
        step(0, 0, 0, 1, 0, 0);
        chk("R5 done clears busy", reg_q, m);
        step(1, 16'h0200, 0, 0, 0, 0);
        chk("R9 write one ignored", {15'd0, reg_q[9]}, 16'd0);
        step(0, 0, 0, 1, 0, 1);
        chk("R5 start and done", {15'd0, reg_q[9]}, 16'd0);
    endtask

    task automatic t_read();
        step(1, 16'h0D57, 0, 0, 0, 0);
        chk("R3 control bits", reg_q, m);
        cop_ctl_in = 16'h0000; #1;
        chk("R1 read cop zero", rd_data, m & ~16'h0C07);
        cop_ctl_in = 16'hFFFF; #1;
        chk("R1 read cop ones", rd_data, (m & ~16'h0C07) | 16'h0C07);
        cop_ctl_in = 16'h0000;
    endtask

    task automatic t_pad();
        step(1, 16'h5000, 0, 0, 0, 0);
        chk("R7 pad stored", reg_q, m);
        chk("R7 pad_err high", {15'd0, pad_err}, 16'd1);
        step(1, 16'h0000, 0, 0, 0, 0);
        chk("R7 pad_err low", {15'd0, pad_err}, 16'd0);
    endtask

    initial begin
        wr_en = 0; wr_data = 0; cop_ctl_in = 0; audio_set = 0; auxdma_set = 0;
        cop_set = 0; auxdma_start = 0; rst = 1; m = 0;
        t_reset();
        t_sources();
        t_w1c();
        t_prio();
        t_busy();
        t_read();
        t_pad();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule